// File: doc/BRIEF.md
# Interrupt priority arbiter

This block chooses which interrupt a hart should take in a given cycle. It receives the pending-interrupt vector, the delegation mask, the current privilege level, the machine and supervisor global enables, and the debug cause field. From these it produces a take strobe and a cause word. The decision is combinational. A parameter can add one output register stage.

Eligibility is checked in two levels. Machine-level interrupts are the pending bits that are not delegated, and they are checked first. The delegated, supervisor-level bits are checked only when no machine-level bit survives. The surviving set is then narrowed to the first non-empty priority group, and the lowest set bit index within that group gives the cause. The trap unit downstream uses the take strobe to enter the handler and writes the cause word into its cause register.

Top module: `irq_prio_arb`

## Requirements
- R1: A non-delegated pending bit is eligible when the privilege is below machine (priv != 3), or when priv == 3 and `m_ie` = 1. When priv == 3 and `m_ie` = 0, no non-delegated bit is taken.
- R2: A delegated pending bit (its `deleg` bit is 1) is eligible only when no non-delegated bit is eligible. It also requires priv == 0, or priv == 1 with `s_ie` = 1. It is never taken at priv == 3. Privilege encoding: user = 0, supervisor = 1, machine = 3.
- R3: When `dbg_cause` is nonzero, `take` is 0 and `cause` is 0, whatever else is pending.
- R4: Among the eligible bits, groups are tried in this order: all bits at index 11 and above, then bit 9 or 11, then bit 1 or 3, then bit 5 or 7. The first non-empty group wins. Because bit 11 falls in the first group, bit 11 beats bit 9.
- R5: Within the winning group, the lowest set index is chosen. If no group holds an eligible bit, the lowest eligible index overall is chosen (for example, bit 0 alone, or bits 0, 2 and 4 together).
- R6: When an interrupt is taken, `take` = 1 and `cause` has bit XLEN-1 set, ORed with the chosen index in the low bits. When nothing is eligible, `take` = 0 and `cause` = 0. XLEN is 32 or 64.
- R7: With `REG_OUT` = 1, `take` and `cause` follow the inputs one clock edge later. While `rst` is high at an edge, that edge clears both outputs (synchronous, active high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| pend | input | XLEN | Pending interrupt bits |
| deleg | input | XLEN | Delegation mask; 1 hands the bit to supervisor level |
| priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| m_ie | input | 1 | Machine global interrupt enable |
| s_ie | input | 1 | Supervisor global interrupt enable |
| dbg_cause | input | 3 | Recorded debug cause; nonzero means debug mode |
| take | output | 1 | An interrupt is to be taken |
| cause | output | XLEN | Interrupt flag in the top bit, chosen index in the low bits |

## Verification
Two functions can act in the same cycle. The machine-level pass and the delegated supervisor pass can both hold pending bits at once, and debug mode can coincide with a fully eligible interrupt. The vector table drives mixed sets of delegated and non-delegated bits at different privileges and enables. It checks that the machine bit wins whenever it is eligible, and that the delegated bit wins only when the machine set is empty. Other rows raise the debug cause alongside interrupts that would otherwise win, and the bench checks that the outputs stay zero.

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int XLEN    = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] pend,
  input  logic [XLEN-1:0] deleg,
  input  logic [1:0]      priv,
  input  logic            m_ie,
  input  logic            s_ie,
  input  logic [2:0]      dbg_cause,
  output logic            take,
  output logic [XLEN-1:0] cause
);
  localparam int IW = $clog2(XLEN);
  localparam logic [XLEN-1:0] ONE    = XLEN'(1);
  localparam logic [XLEN-1:0] HI_GRP = ~((ONE << 11) - ONE);
  localparam logic [XLEN-1:0] EX_GRP = (ONE << 11) | (ONE << 9);
  localparam logic [XLEN-1:0] SW_GRP = (ONE << 3) | (ONE << 1);
  localparam logic [XLEN-1:0] TM_GRP = (ONE << 7) | (ONE << 5);
  localparam logic [XLEN-1:0] FLAG   = ONE << (XLEN - 1);

  logic            m_ok, s_ok, in_dbg;
  logic [XLEN-1:0] m_set, s_set, elig, grp;
  logic [IW-1:0]   sel;
  logic            take_c;
  logic [XLEN-1:0] cause_c;

  assign m_ok   = (priv != 2'd3) || m_ie;
  assign s_ok   = (priv == 2'd0) || ((priv == 2'd1) && s_ie);
  assign in_dbg = |dbg_cause;
  assign m_set  = pend & ~deleg & {XLEN{m_ok}};
  assign s_set  = pend & deleg & {XLEN{s_ok}};
  assign elig   = (|m_set) ? m_set : s_set;

  always_comb begin
    if (|(elig & HI_GRP))      grp = elig & HI_GRP;
    else if (|(elig & EX_GRP)) grp = elig & EX_GRP;
    else if (|(elig & SW_GRP)) grp = elig & SW_GRP;
    else if (|(elig & TM_GRP)) grp = elig & TM_GRP;
    else                       grp = elig;
  end

  always_comb begin
    sel = '0;
    for (int i = XLEN - 1; i >= 0; i--)
      if (grp[i]) sel = IW'(i);
  end

  assign take_c  = !in_dbg && (|elig);
  assign cause_c = take_c ? (FLAG | XLEN'(sel)) : '0;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          take  <= 1'b0;
          cause <= '0;
        end else begin
          take  <= take_c;
          cause <= cause_c;
        end
      end

      p_reset_clear_r7: assert property (@(posedge clk)
        rst |=> (!take && cause == '0));
      p_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (take == $past(take_c) && cause == $past(cause_c)));
    end else begin : g_comb
      assign take  = take_c;
      assign cause = cause_c;
    end
  endgenerate

  p_mach_gate_r1: assert property (@(posedge clk) disable iff (rst)
    (take_c && !deleg[sel]) |-> (priv != 2'd3 || m_ie));
  p_deleg_gate_r2: assert property (@(posedge clk) disable iff (rst)
    (take_c && deleg[sel]) |-> (priv == 2'd0 || (priv == 2'd1 && s_ie)));
  p_dbg_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (dbg_cause != 3'd0) |-> (!take_c && cause_c == '0));
  p_pick_pending_r5: assert property (@(posedge clk) disable iff (rst)
    take_c |-> pend[sel]);
endmodule

// File: tb/sim_irq_prio_arb.sv
module sim_irq_prio_arb;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] pend, deleg;
  logic [1:0]  priv;
  logic        m_ie, s_ie;
  logic [2:0]  dbg_cause;
  logic        take;
  logic [31:0] cause;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  irq_prio_arb #(.XLEN(32), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst(rst), .pend(pend), .deleg(deleg), .priv(priv),
    .m_ie(m_ie), .s_ie(s_ie), .dbg_cause(dbg_cause),
    .take(take), .cause(cause)
  );

  // {pend, deleg, priv, m_ie, s_ie, dbg, exp_take, exp_idx, req}
  localparam int N = 22;
  localparam logic [80:0] TBL [N] = '{
    {32'h80,   32'h0,  2'd3, 1'b1, 1'b0, 3'd0, 1'b1, 5'd7,  4'd1}, // R1 M level enabled
    {32'h80,   32'h0,  2'd3, 1'b0, 1'b0, 3'd0, 1'b0, 5'd0,  4'd1}, // R1 M level disabled
    {32'h80,   32'h0,  2'd1, 1'b0, 1'b0, 3'd0, 1'b1, 5'd7,  4'd1}, // R1 below M ignores m_ie
    {32'h20,   32'h20, 2'd0, 1'b0, 1'b0, 3'd0, 1'b1, 5'd5,  4'd2}, // R2 user takes delegated
    {32'h20,   32'h20, 2'd1, 1'b0, 1'b0, 3'd0, 1'b0, 5'd0,  4'd2}, // R2 S with s_ie low
    {32'h20,   32'h20, 2'd1, 1'b0, 1'b1, 3'd0, 1'b1, 5'd5,  4'd2}, // R2 S with s_ie high
    {32'h20,   32'h20, 2'd3, 1'b1, 1'b1, 3'd0, 1'b0, 5'd0,  4'd2}, // R2 never at M
    {32'hA0,   32'h20, 2'd1, 1'b0, 1'b1, 3'd0, 1'b1, 5'd7,  4'd2}, // R2 M set wins first
    {32'hA0,   32'h20, 2'd3, 1'b0, 1'b1, 3'd0, 1'b0, 5'd0,  4'd2}, // R2 both blocked
    {32'h02,   32'h02, 2'd0, 1'b0, 1'b0, 3'd0, 1'b1, 5'd1,  4'd2}, // R2 delegated software
    {32'h22,   32'h22, 2'd1, 1'b0, 1'b1, 3'd0, 1'b1, 5'd1,  4'd4}, // R4 sw over timer
    {32'h2AA,  32'h0,  2'd3, 1'b1, 1'b0, 3'd0, 1'b1, 5'd9,  4'd4}, // R4 ext over rest
    {32'h1200, 32'h0,  2'd3, 1'b1, 1'b0, 3'd0, 1'b1, 5'd12, 4'd4}, // R4 high over ext
    {32'h88,   32'h0,  2'd3, 1'b1, 1'b0, 3'd0, 1'b1, 5'd3,  4'd4}, // R4 sw over timer
    {32'hA00,  32'h0,  2'd3, 1'b1, 1'b0, 3'd0, 1'b1, 5'd11, 4'd4}, // R4 bit 11 over 9
    {32'h0A,   32'h0,  2'd3, 1'b1, 1'b0, 3'd0, 1'b1, 5'd1,  4'd5}, // R5 lowest in pair
    {32'h30000,32'h0,  2'd3, 1'b1, 1'b0, 3'd0, 1'b1, 5'd16, 4'd5}, // R5 lowest in high
    {32'h15,   32'h0,  2'd3, 1'b1, 1'b0, 3'd0, 1'b1, 5'd0,  4'd5}, // R5 fallback lowest
    {32'h21,   32'h0,  2'd0, 1'b0, 1'b0, 3'd0, 1'b1, 5'd5,  4'd5}, // R5 group beats ungrouped
    {32'h800,  32'h0,  2'd3, 1'b1, 1'b0, 3'd1, 1'b0, 5'd0,  4'd3}, // R3 debug blocks M
    {32'h20,   32'h20, 2'd0, 1'b0, 1'b0, 3'd4, 1'b0, 5'd0,  4'd3}, // R3 debug blocks S
    {32'h80000000, 32'h0, 2'd3, 1'b1, 1'b0, 3'd0, 1'b1, 5'd31, 4'd6} // R6 top index
  };

  function automatic logic [31:0] exp_cause(input logic t, input logic [4:0] i);
    return t ? (32'h8000_0000 | 32'(i)) : 32'h0;
  endfunction

  task automatic check(input string req, input logic et, input logic [31:0] ec);
    checks++;
    if (take !== et || cause !== ec) begin
      errors++;
      $display("FAIL %s take=%0b cause=%h expected take=%0b cause=%h",
               req, take, cause, et, ec);
    end
  endtask

  task automatic drive(input logic [31:0] p, input logic [31:0] d, input logic [1:0] pv,
                       input logic mi, input logic si, input logic [2:0] db);
    pend = p; deleg = d; priv = pv; m_ie = mi; s_ie = si; dbg_cause = db;
  endtask

  initial begin
    rst = 1'b1;
    drive(32'h80, 32'h0, 2'd3, 1'b1, 1'b0, 3'd0);
    repeat (3) @(negedge clk);
    check("R7 reset state", 1'b0, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R7 after release", 1'b1, exp_cause(1'b1, 5'd7));

    drive(32'h0, 32'h0, 2'd3, 1'b1, 1'b0, 3'd0);
    @(negedge clk);
    check("R6 nothing pending", 1'b0, 32'h0);

    for (int k = 0; k < N; k++) begin
      drive(TBL[k][80:49], TBL[k][48:17], TBL[k][16:15], TBL[k][14], TBL[k][13], TBL[k][12:10]);
      @(negedge clk);
      checks++;
      if (take !== TBL[k][9] || cause !== exp_cause(TBL[k][9], TBL[k][8:4])) begin
        errors++;
        $display("FAIL R%0d vector %0d take=%0b cause=%h expected take=%0b cause=%h",
                 TBL[k][3:0], k, take, cause, TBL[k][9], exp_cause(TBL[k][9], TBL[k][8:4]));
      end
    end

    // R7 latency: outputs hold until the next edge
    drive(32'h0, 32'h0, 2'd3, 1'b1, 1'b0, 3'd0);
    @(negedge clk);
    drive(32'h8, 32'h0, 2'd3, 1'b1, 1'b0, 3'd0);
    #1;
    check("R7 before edge", 1'b0, 32'h0);
    @(negedge clk);
    check("R7 after edge", 1'b1, exp_cause(1'b1, 5'd3));

    // R7 reset in the middle of a take
    rst = 1'b1;
    @(negedge clk);
    check("R7 mid-run reset", 1'b0, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R7 resume", 1'b1, exp_cause(1'b1, 5'd3));

    // R3 debug raised while a take is active drops the take next cycle
    dbg_cause = 3'd2;
    @(negedge clk);
    check("R3 debug while active", 1'b0, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule